// File: doc/BRIEF.md
# CAN Bit Timing Unit with Edge Resynchronization

This block turns a fast system clock into the bit timing of a CAN node. A prescaler divides the clock into time quanta, and each bit is built from one synchronization quantum, a first phase segment whose end is the sample point, and a second phase segment whose end is the transmit point. The block emits a one-cycle sample strobe, a one-cycle transmit strobe and the bit value captured at the sample point. Two complete timing sets are provided: one for arbitration and one for the data phase. A single select input chooses which set is active.

The raw receive line passes through a two-flop synchronizer and is examined once per quantum. A falling transition is treated as a timing edge. While the bus is idle, such an edge restarts the bit; that is a hard synchronization. Otherwise, the first edge in a bit adjusts the bit phase. An edge that lands in the first segment lengthens that segment. An edge that lands in the second segment shortens it. The size of either correction is limited by the jump width. Edges seen while the node drives a dominant level are not used for correction. Frame decoding, stuffing and error handling belong to the blocks that consume the strobes.

Top module: `can_bit_timer`

## Requirements
- R1: A quantum lasts max(P,1) clocks, where P is the active prescaler. A bit with no correction lasts 1+B1+B2 quanta, and its sample strobe comes 1+B1 quanta after the transmit strobe that opens the bit. A zero B1 or B2 setting is treated as 1.
- R2: `data_phase`=0 selects the `nom_*` timing set and `data_phase`=1 selects the `dat_*` set.
- R3: RX is dominant low. At each sample strobe, `rx_bit` takes the synchronized RX level and holds it until the next strobe. After reset, both strobes are low and `rx_bit` is 1.
- R4: A falling edge seen in the synchronization quantum (quantum 0) causes no change to bit length.
- R5: A falling edge seen in quantum k of segment 1 (k=1 for its first quantum) lengthens segment 1 by min(k, SJW) quanta. SJW is clamped to 1..4.
- R6: A falling edge seen in segment 2 with r quanta of that segment left after the edge quantum shortens segment 2 by min(r, SJW). When r ≤ SJW, the bit ends with the edge quantum.
- R7: Only the first falling edge in a bit can adjust it. Later edges in the same bit leave its length unchanged.
- R8: While `tx_dom` is 1, a falling edge makes no adjustment.
- R9: While `bus_idle` is 1, a falling edge makes its own quantum the synchronization quantum. The sample strobe follows B1 quanta later, and the interrupted bit produces no transmit strobe.
- R10: With a 1+13+2 quanta setting, the sample point falls between 80% and 90% of the bit.
- R11: The sample and transmit strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_phase | input | 1 | 0 = arbitration timing set, 1 = data timing set |
| nom_presc | input | PW | Arbitration prescaler (clocks per quantum) |
| nom_bs1 | input | S1W | Arbitration segment 1 length in quanta |
| nom_bs2 | input | S2W | Arbitration segment 2 length in quanta |
| nom_sjw | input | JW | Arbitration jump width in quanta |
| dat_presc | input | PW | Data prescaler |
| dat_bs1 | input | S1W | Data segment 1 length |
| dat_bs2 | input | S2W | Data segment 2 length |
| dat_sjw | input | JW | Data jump width |
| bus_idle | input | 1 | High while no frame is in progress; enables hard synchronization |
| tx_dom | input | 1 | High while this node drives a dominant level |
| rx_in | input | 1 | Raw, asynchronous receive line |
| sample_stb | output | 1 | One-cycle pulse at each sample point |
| tx_stb | output | 1 | One-cycle pulse at each transmit point (bit start) |
| rx_bit | output | 1 | Bit value captured at the last sample point |

## Verification
Both strobes are registered and appear in the clock after the quantum tick that ends their segment. The bench therefore measures every result as a clock count from the transmit strobe that opens the measured bit, and never as an absolute time. A level change on `rx_in` is seen by the sequencer at the first quantum tick at least three clocks later: two synchronizer flops plus the tick's own register. Edges are driven j·P clocks after the opening strobe, with P ≥ 4, so each edge falls unambiguously in quantum j. The expected sample and end counts are (1+B1±correction)·P and (1+B1+B2±correction)·P. A queue holds them, and the checks compare them at the cycle where each strobe is visible.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC = 2'd0,
        SEG_BS1  = 2'd1,
        SEG_BS2  = 2'd2
    } seg_e;

endpackage

// File: rtl/bt_quantum_gen.sv
module bt_quantum_gen #(
    parameter int PW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] presc,
    output logic          tick
);
    typedef struct packed {
        logic [PW-1:0] cnt;
    } qg_st_t;

    qg_st_t        st_d, st_q;
    logic [PW-1:0] presc_eff;

    always_comb begin
        presc_eff = (presc == '0) ? PW'(1) : presc;
        tick      = (st_q.cnt >= presc_eff - PW'(1));
        st_d      = st_q;
        st_d.cnt  = tick ? '0 : st_q.cnt + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1: with a constant prescaler above one, ticks are never back to back
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && presc > PW'(1)) |=> (!tick || !$stable(presc)));

endmodule

// File: rtl/bt_rx_edge.sv
module bt_rx_edge #(
    parameter int NS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_in,
    input  logic tick,
    output logic rx_lvl,
    output logic fall_evt
);
    typedef struct packed {
        logic [NS-1:0] sync;
        logic          tq_lvl;
    } rxe_st_t;

    rxe_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[NS-2:0], rx_in};
        if (tick) st_d.tq_lvl = st_q.sync[NS-1];
        rx_lvl   = st_q.sync[NS-1];
        fall_evt = tick && st_q.tq_lvl && !st_q.sync[NS-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '1;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/bt_seq.sv
module bt_seq
    import can_bt_pkg::*;
#(
    parameter int S1W = 5,
    parameter int S2W = 4,
    parameter int JW  = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           fall_evt,
    input  logic           bus_idle,
    input  logic           tx_dom,
    input  logic           rx_lvl,
    input  logic [S1W-1:0] bs1,
    input  logic [S2W-1:0] bs2,
    input  logic [JW-1:0]  sjw,
    output logic           sample_stb,
    output logic           tx_stb,
    output logic           rx_bit
);
    localparam int LW = S1W + 2;
    localparam logic [LW-1:0] ONE = LW'(1);

    typedef struct packed {
        seg_e          seg;
        logic [LW-1:0] qcnt;
        logic [LW-1:0] lim;
        logic          used;
        logic          smp;
        logic          txs;
        logic          rxb;
    } seq_st_t;

    localparam seq_st_t ST_RST = '{seg: SEG_SYNC, qcnt: '0, lim: '0,
                                   used: 1'b0, smp: 1'b0, txs: 1'b0, rxb: 1'b1};

    seq_st_t       st_d, st_q;
    logic          take;
    logic [LW-1:0] sjw_w, q_next, step, r_left, lim_x;

    always_comb begin
        st_d     = st_q;
        st_d.smp = 1'b0;
        st_d.txs = 1'b0;
        take     = fall_evt && !tx_dom && !st_q.used;
        sjw_w    = LW'(sjw);
        q_next   = st_q.qcnt + ONE;
        step     = '0;
        r_left   = '0;
        lim_x    = st_q.lim;
        if (tick) begin
            if (fall_evt && bus_idle) begin
                st_d.seg  = SEG_BS1;
                st_d.qcnt = '0;
                st_d.lim  = LW'(bs1);
                st_d.used = 1'b1;
            end else begin
                case (st_q.seg)
                    SEG_SYNC: begin
                        st_d.seg  = SEG_BS1;
                        st_d.qcnt = '0;
                        st_d.lim  = LW'(bs1);
                        if (take) st_d.used = 1'b1;
                    end
                    SEG_BS1: begin
                        if (take) begin
                            step      = (q_next < sjw_w) ? q_next : sjw_w;
                            st_d.used = 1'b1;
                        end
                        lim_x = st_q.lim + step;
                        if (q_next >= lim_x) begin
                            st_d.seg  = SEG_BS2;
                            st_d.qcnt = '0;
                            st_d.lim  = LW'(bs2);
                            st_d.smp  = 1'b1;
                            st_d.rxb  = rx_lvl;
                        end else begin
                            st_d.qcnt = q_next;
                            st_d.lim  = lim_x;
                        end
                    end
                    SEG_BS2: begin
                        r_left = st_q.lim - q_next;
                        if (take) begin
                            step      = (r_left < sjw_w) ? r_left : sjw_w;
                            st_d.used = 1'b1;
                        end
                        lim_x = st_q.lim - step;
                        if (q_next >= lim_x) begin
                            st_d.seg  = SEG_SYNC;
                            st_d.qcnt = '0;
                            st_d.used = 1'b0;
                            st_d.txs  = 1'b1;
                        end else begin
                            st_d.qcnt = q_next;
                            st_d.lim  = lim_x;
                        end
                    end
                    default: st_d.seg = SEG_SYNC;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign sample_stb = st_q.smp;
    assign tx_stb     = st_q.txs;
    assign rx_bit     = st_q.rxb;

    // R11: strobes are mutually exclusive
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && tx_stb));

    // R1: a sample strobe always follows a quantum tick
    p_sample_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> $past(tick));

    // R3: the captured bit only moves with a sample strobe
    p_rxbit_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_stb |-> $stable(rx_bit));

    // R9: an idle-bus edge restarts the bit in segment 1 without a transmit strobe
    p_hard_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && fall_evt && bus_idle) |=>
        (st_q.seg == SEG_BS1 && st_q.qcnt == '0 && !tx_stb));

    // R5: a taken segment-1 edge grows the segment by 1..SJW quanta
    p_ext_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && fall_evt && !tx_dom && !bus_idle && !st_q.used && st_q.seg == SEG_BS1) |=>
        (st_q.lim > $past(st_q.lim) && st_q.lim <= $past(st_q.lim) + LW'($past(sjw))));

    // R8: an edge while driving dominant leaves segment 1 untouched
    p_txdom_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && fall_evt && tx_dom && !bus_idle && st_q.seg == SEG_BS1 &&
         (st_q.qcnt + ONE < st_q.lim)) |=> (st_q.lim == $past(st_q.lim)));

    // R7: a second edge in segment 2 leaves it untouched
    p_first_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && fall_evt && st_q.used && !bus_idle && st_q.seg == SEG_BS2 &&
         (st_q.qcnt + ONE < st_q.lim)) |=> (st_q.lim == $past(st_q.lim)));

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
    parameter int PW      = 10,
    parameter int S1W     = 5,
    parameter int S2W     = 4,
    parameter int JW      = 3,
    parameter int SJW_MAX = 4,
    parameter int NS      = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           data_phase,
    input  logic [PW-1:0]  nom_presc,
    input  logic [S1W-1:0] nom_bs1,
    input  logic [S2W-1:0] nom_bs2,
    input  logic [JW-1:0]  nom_sjw,
    input  logic [PW-1:0]  dat_presc,
    input  logic [S1W-1:0] dat_bs1,
    input  logic [S2W-1:0] dat_bs2,
    input  logic [JW-1:0]  dat_sjw,
    input  logic           bus_idle,
    input  logic           tx_dom,
    input  logic           rx_in,
    output logic           sample_stb,
    output logic           tx_stb,
    output logic           rx_bit
);
    logic [PW-1:0]  act_presc;
    logic [S1W-1:0] sel_bs1, act_bs1;
    logic [S2W-1:0] sel_bs2, act_bs2;
    logic [JW-1:0]  sel_sjw, act_sjw;
    logic           tick, rx_lvl, fall_evt;

    always_comb begin
        act_presc = data_phase ? dat_presc : nom_presc;
        sel_bs1   = data_phase ? dat_bs1   : nom_bs1;
        sel_bs2   = data_phase ? dat_bs2   : nom_bs2;
        sel_sjw   = data_phase ? dat_sjw   : nom_sjw;
        act_bs1   = (sel_bs1 == '0) ? S1W'(1) : sel_bs1;
        act_bs2   = (sel_bs2 == '0) ? S2W'(1) : sel_bs2;
        if (sel_sjw == '0)                 act_sjw = JW'(1);
        else if (sel_sjw > JW'(SJW_MAX))   act_sjw = JW'(SJW_MAX);
        else                               act_sjw = sel_sjw;
    end

    bt_quantum_gen #(.PW(PW)) i_qgen (
        .clk   (clk),
        .rst_n (rst_n),
        .presc (act_presc),
        .tick  (tick)
    );

    bt_rx_edge #(.NS(NS)) i_rxe (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_in    (rx_in),
        .tick     (tick),
        .rx_lvl   (rx_lvl),
        .fall_evt (fall_evt)
    );

    bt_seq #(.S1W(S1W), .S2W(S2W), .JW(JW)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .fall_evt   (fall_evt),
        .bus_idle   (bus_idle),
        .tx_dom     (tx_dom),
        .rx_lvl     (rx_lvl),
        .bs1        (act_bs1),
        .bs2        (act_bs2),
        .sjw        (act_sjw),
        .sample_stb (sample_stb),
        .tx_stb     (tx_stb),
        .rx_bit     (rx_bit)
    );

endmodule

// File: tb/test_can_bit_timer.sv
`timescale 1ns/1ps
module test_can_bit_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_phase = 1'b0;
    logic [9:0] nom_presc = 10'd8, dat_presc = 10'd4;
    logic [4:0] nom_bs1 = 5'd6, dat_bs1 = 5'd13;
    logic [3:0] nom_bs2 = 4'd4, dat_bs2 = 4'd2;
    logic [2:0] nom_sjw = 3'd2, dat_sjw = 3'd4;
    logic       bus_idle = 1'b0, tx_dom = 1'b0, rx_in = 1'b1;
    logic       sample_stb, tx_stb, rx_bit;

    always #2.5 clk = ~clk;

    can_bit_timer i_can_bit_timer (
        .clk(clk), .rst_n(rst_n), .data_phase(data_phase),
        .nom_presc(nom_presc), .nom_bs1(nom_bs1), .nom_bs2(nom_bs2), .nom_sjw(nom_sjw),
        .dat_presc(dat_presc), .dat_bs1(dat_bs1), .dat_bs2(dat_bs2), .dat_sjw(dat_sjw),
        .bus_idle(bus_idle), .tx_dom(tx_dom), .rx_in(rx_in),
        .sample_stb(sample_stb), .tx_stb(tx_stb), .rx_bit(rx_bit)
    );

    typedef struct {
        int    samp;
        int    bitc;
        logic  rxb;
        string req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0, n_fail = 0, overlap = 0;
    int   last_samp = 0, last_bit = 0;

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_tx();
        do @(negedge clk); while (tx_stb !== 1'b1);
    endtask

    // driver: w1 = clocks after the opening strobe for the fall (-1: none),
    // w2/w3 = optional rise and second fall
    task automatic run_case(input int w1, input int w2, input int w3,
                            input logic dph, input logic idle, input logic dom,
                            input int samp, input int bitc, input logic rxb,
                            input string req);
        exp_t e;
        rx_in = 1'b1; data_phase = dph; bus_idle = 1'b0; tx_dom = dom;
        wait_tx();
        wait_tx();
        bus_idle = idle;
        e.samp = samp; e.bitc = bitc; e.rxb = rxb; e.req = req;
        exp_q.push_back(e);
        wait_tx();
        if (w1 >= 0) begin
            repeat (w1) @(negedge clk);
            rx_in = 1'b0;
            if (w2 >= 0) begin
                repeat (w2 - w1) @(negedge clk);
                rx_in = 1'b1;
                repeat (w3 - w2) @(negedge clk);
                rx_in = 1'b0;
            end
        end
        while (exp_q.size() != 0) @(negedge clk);
        bus_idle = 1'b0; tx_dom = 1'b0; rx_in = 1'b1;
    endtask

    // monitor: measures the bit opened by the strobe after an item is queued
    initial begin
        bit   active = 1'b0, pend = 1'b0;
        int   cnt = 0, nsamp = 0;
        exp_t cur;
        forever begin
            @(negedge clk);
            if (sample_stb === 1'b1 && tx_stb === 1'b1) overlap++;
            if (active) cnt++;
            if (active && sample_stb === 1'b1) begin
                nsamp++;
                check({cur.req, " sample clocks"}, cnt, cur.samp);
                check({cur.req, " R3 rx_bit"}, int'(rx_bit), int'(cur.rxb));
                last_samp = cnt;
            end
            if (tx_stb === 1'b1) begin
                if (active) begin
                    check({cur.req, " bit clocks"}, cnt, cur.bitc);
                    check({cur.req, " sample count"}, nsamp, 1);
                    last_bit = cnt;
                    void'(exp_q.pop_front());
                    active = 1'b0;
                end else if (pend && exp_q.size() != 0) begin
                    cur = exp_q[0];
                    active = 1'b1;
                    cnt = 0;
                    nsamp = 0;
                end
            end
            pend = (exp_q.size() != 0);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check("R3 reset sample_stb", int'(sample_stb), 0);
        check("R3 reset tx_stb", int'(tx_stb), 0);
        check("R3 reset rx_bit", int'(rx_bit), 1);
        rst_n = 1'b1;
        // arbitration set: P=8, 1+6+4 quanta, SJW 2
        run_case(-1, -1, -1, 1'b0, 1'b0, 1'b0, 56, 88, 1'b1, "R1 plain bit");
        run_case(0, -1, -1, 1'b0, 1'b0, 1'b0, 56, 88, 1'b0, "R4 edge in sync");
        run_case(8, -1, -1, 1'b0, 1'b0, 1'b0, 64, 96, 1'b0, "R5 seg1 q1");
        run_case(32, -1, -1, 1'b0, 1'b0, 1'b0, 72, 104, 1'b0, "R5 seg1 q4 capped");
        run_case(72, -1, -1, 1'b0, 1'b0, 1'b0, 56, 80, 1'b1, "R6 seg2 r1");
        run_case(56, -1, -1, 1'b0, 1'b0, 1'b0, 56, 72, 1'b1, "R6 seg2 r3 capped");
        run_case(80, -1, -1, 1'b0, 1'b0, 1'b0, 56, 88, 1'b1, "R6 seg2 last quantum");
        run_case(32, -1, -1, 1'b0, 1'b0, 1'b1, 56, 88, 1'b0, "R8 driving dominant");
        run_case(8, 24, 64, 1'b0, 1'b0, 1'b0, 64, 96, 1'b1, "R7 second edge");
        run_case(24, -1, -1, 1'b0, 1'b1, 1'b0, 80, 112, 1'b0, "R9 hard sync");
        // data set: P=4, 1+13+2 quanta, SJW 4
        run_case(-1, -1, -1, 1'b1, 1'b0, 1'b0, 56, 64, 1'b1, "R2 data plain");
        n_checks++;
        if (last_bit == 0 || last_samp * 100 < last_bit * 80 || last_samp * 100 > last_bit * 90) begin
            n_fail++;
            $display("FAIL R10 sample point actual=%0d/%0d expected=80..90 pct", last_samp, last_bit);
        end
        run_case(12, -1, -1, 1'b1, 1'b0, 1'b0, 68, 76, 1'b0, "R2 R5 data seg1 q3");
        run_case(56, -1, -1, 1'b1, 1'b0, 1'b0, 56, 60, 1'b1, "R2 R6 data seg2 r1");
        run_case(24, -1, -1, 1'b1, 1'b0, 1'b0, 72, 80, 1'b0, "R2 R5 data SJW 4 cap");
        check("R11 strobe overlap", overlap, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule